// File: doc/BRIEF.md
# Dataflow Operand Pairing Unit

This block sits at the entry of one processing element in a dataflow machine. Each incoming token carries a two-bit kind code. The unit reads that code and sends the token to one of four places. Single-input operand tokens go straight to the execution stage. Structure-memory tokens leave unchanged on a memory output. System tokens leave unchanged on a system output. Two-input operand tokens are held in a matching store until their partner arrives.

The matching store keeps one entry for each combination of context slot and instruction offset. An entry records a valid bit, the port the waiting operand came in on (left or right), its generation and its data. A partner with the opposite port and the same generation completes the pair. The unit then emits one fire packet with the left operand and the right operand in fixed positions, and frees the entry. A token whose generation disagrees with the waiting entry is discarded and counted. A second token on the same port and generation replaces the waiting one and raises an error pulse.

Each result appears on its outputs one clock after the token is accepted. After reset, the unit clears the store one entry per cycle and holds its input ready low until the clearing is finished.

Top module: `operand_pairing_unit`

## Requirements
- R1: While reset is asserted, and right after it, all output valid strobes, `dupError` and `staleCount` are 0. `inReady` stays low for exactly 2^(OFS_W+CTX_W) clock cycles after reset is released, then stays high.
- R2: Field layout of `inToken`, from the most significant bit down: kind (2 bits), offset (OFS_W), context (CTX_W), port (1 bit, 0 = left, 1 = right), generation (GEN_W), flag (1 bit), data (DATA_W). When a token of kind 01 is accepted, `monoValid` pulses in the next cycle with its offset, context, data and flag (the flag is the inline flag). The matching store is not touched.
- R3: When a token of kind 10 is accepted, `memValid` pulses in the next cycle and `memToken` holds the whole token. When a token of kind 11 is accepted, `sysValid` and `sysToken` behave the same way. At most one output valid strobe is high in any cycle.
- R4: A kind 00 token whose context and offset key finds no waiting entry is stored and produces no output. Entries with different keys never pair, including keys that share an offset but differ in context.
- R5: A kind 00 token that finds a waiting entry with the opposite port and the same generation makes `fireValid` pulse in the next cycle, with the offset, context and generation. It also frees the entry, so the next token with that key is stored again.
- R6: In a fire packet, `fireLeft` holds the port-0 operand and `fireRight` holds the port-1 operand, whichever arrived first. `fireWide` is the OR of the two tokens' flag bits (the width flag).
- R7: A kind 00 token whose generation differs from the waiting entry's generation is dropped with no output. `staleCount` then rises by one, and the waiting entry stays in place for its true partner.
- R8: A kind 00 token with the same port and generation as the waiting entry replaces its data. `dupError` pulses for one cycle and there is no fire. A later partner pairs with the newer data.
- R9: `staleCount` saturates at 2^STALE_W-1.
- R10: Tokens may be accepted on back-to-back cycles. A token sees the store as updated by the token accepted in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Token offered |
| inReady | output | 1 | Unit can accept a token |
| inToken | input | 2+OFS_W+CTX_W+1+GEN_W+1+DATA_W | Incoming token |
| fireValid | output | 1 | Paired fire packet valid |
| fireOffset | output | OFS_W | Instruction offset of the pair |
| fireCtx | output | CTX_W | Context slot of the pair |
| fireGen | output | GEN_W | Generation of the pair |
| fireWide | output | 1 | OR of both width flags |
| fireLeft | output | DATA_W | Left-port operand |
| fireRight | output | DATA_W | Right-port operand |
| monoValid | output | 1 | Single-input packet valid |
| monoOffset | output | OFS_W | Instruction offset |
| monoCtx | output | CTX_W | Context slot |
| monoInline | output | 1 | Inline flag |
| monoData | output | DATA_W | Operand |
| memValid | output | 1 | Structure-memory token valid |
| memToken | output | 2+OFS_W+CTX_W+1+GEN_W+1+DATA_W | Forwarded token |
| sysValid | output | 1 | System token valid |
| sysToken | output | 2+OFS_W+CTX_W+1+GEN_W+1+DATA_W | Forwarded token |
| staleCount | output | STALE_W | Saturating count of dropped generation mismatches |
| dupError | output | 1 | One-cycle pulse on same-port overwrite |

## Verification
The bench builds the unit with a 3-bit offset and a 1-bit context. This gives a 16-entry store, so the clearing phase after reset is short enough to time exactly, and keys that differ only in context can be tried. The generation is 2 bits wide, which allows a mismatched generation right next to a matching one on the same key. The stale counter is 2 bits wide, so three dropped tokens reach saturation and a fourth shows that the count holds.

// File: rtl/opu_pkg.sv
`timescale 1ns/1ps
package opu_pkg;

  typedef enum logic [1:0] {
    KIND_DYAD = 2'b00,
    KIND_MONO = 2'b01,
    KIND_MEM  = 2'b10,
    KIND_SYS  = 2'b11
  } tokKind_e;

  // result of the combinational store lookup for the offered token
  typedef struct packed {
    logic hit;
    logic portSame;
    logic genSame;
  } lookup_t;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic sweepClr;
    logic storeWr;
    logic storeClr;
    logic fireEn;
    logic monoEn;
    logic memEn;
    logic sysEn;
    logic staleInc;
    logic dupPulse;
  } strobes_t;

endpackage

// File: rtl/opu_ctrl.sv
`timescale 1ns/1ps
module opu_ctrl
  import opu_pkg::*;
#(
  parameter int KEY_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  tokKind_e         tokKind,
  input  lookup_t          look,
  output logic             inReady,
  output logic [KEY_W-1:0] sweepIdx,
  output strobes_t         str
);

  typedef enum logic {ST_SWEEP, ST_RUN} state_e;
  state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_SWEEP;
      sweepIdx <= '0;
    end else if (state == ST_SWEEP) begin
      sweepIdx <= sweepIdx + 1'b1;
      if (sweepIdx == '1) state <= ST_RUN;
    end
  end

  assign inReady = (state == ST_RUN);

  logic accept;
  assign accept = inValid && inReady;

  always_comb begin
    str          = '0;
    str.sweepClr = (state == ST_SWEEP);
    if (accept) begin
      unique case (tokKind)
        KIND_MONO: str.monoEn = 1'b1;
        KIND_MEM:  str.memEn  = 1'b1;
        KIND_SYS:  str.sysEn  = 1'b1;
        default: begin
          if (!look.hit) begin
            str.storeWr = 1'b1;
          end else if (!look.genSame) begin
            str.staleInc = 1'b1;
          end else if (look.portSame) begin
            str.storeWr  = 1'b1;
            str.dupPulse = 1'b1;
          end else begin
            str.fireEn   = 1'b1;
            str.storeClr = 1'b1;
          end
        end
      endcase
    end
  end

  // R1
  ready_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);

endmodule

// File: rtl/opu_datapath.sv
`timescale 1ns/1ps
module opu_datapath
  import opu_pkg::*;
#(
  parameter int OFS_W   = 4,
  parameter int CTX_W   = 2,
  parameter int GEN_W   = 2,
  parameter int DATA_W  = 16,
  parameter int STALE_W = 8,
  localparam int KEY_W  = OFS_W + CTX_W,
  localparam int DEPTH  = 1 << KEY_W,
  localparam int TOK_W  = 2 + OFS_W + CTX_W + 1 + GEN_W + 1 + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOK_W-1:0]   inToken,
  input  strobes_t           str,
  input  logic [KEY_W-1:0]   sweepIdx,
  output tokKind_e           tokKind,
  output lookup_t            look,
  output logic               fireValid,
  output logic [OFS_W-1:0]   fireOffset,
  output logic [CTX_W-1:0]   fireCtx,
  output logic [GEN_W-1:0]   fireGen,
  output logic               fireWide,
  output logic [DATA_W-1:0]  fireLeft,
  output logic [DATA_W-1:0]  fireRight,
  output logic               monoValid,
  output logic [OFS_W-1:0]   monoOffset,
  output logic [CTX_W-1:0]   monoCtx,
  output logic               monoInline,
  output logic [DATA_W-1:0]  monoData,
  output logic               memValid,
  output logic [TOK_W-1:0]   memToken,
  output logic               sysValid,
  output logic [TOK_W-1:0]   sysToken,
  output logic [STALE_W-1:0] staleCount,
  output logic               dupError
);

  localparam int FLAG_B  = DATA_W;
  localparam int GEN_LO  = FLAG_B + 1;
  localparam int PORT_B  = GEN_LO + GEN_W;
  localparam int CTX_LO  = PORT_B + 1;
  localparam int OFS_LO  = CTX_LO + CTX_W;
  localparam int KIND_LO = OFS_LO + OFS_W;

  logic [DATA_W-1:0] inData;
  logic              inFlag;
  logic [GEN_W-1:0]  inGen;
  logic              inPort;
  logic [CTX_W-1:0]  inCtx;
  logic [OFS_W-1:0]  inOfs;
  logic [KEY_W-1:0]  inKey;

  assign inData  = inToken[DATA_W-1:0];
  assign inFlag  = inToken[FLAG_B];
  assign inGen   = inToken[GEN_LO +: GEN_W];
  assign inPort  = inToken[PORT_B];
  assign inCtx   = inToken[CTX_LO +: CTX_W];
  assign inOfs   = inToken[OFS_LO +: OFS_W];
  assign inKey   = {inCtx, inOfs};
  assign tokKind = tokKind_e'(inToken[KIND_LO +: 2]);

  // matching store: valid bits cleared by the post-reset sweep
  logic              entValid [DEPTH];
  logic              entPort  [DEPTH];
  logic [GEN_W-1:0]  entGen   [DEPTH];
  logic              entWide  [DEPTH];
  logic [DATA_W-1:0] entData  [DEPTH];

  always_ff @(posedge clk) begin
    if (str.sweepClr) entValid[sweepIdx] <= 1'b0;
    if (str.storeWr) begin
      entValid[inKey] <= 1'b1;
      entPort[inKey]  <= inPort;
      entGen[inKey]   <= inGen;
      entWide[inKey]  <= inFlag;
      entData[inKey]  <= inData;
    end
    if (str.storeClr) entValid[inKey] <= 1'b0;
  end

  assign look.hit      = entValid[inKey];
  assign look.portSame = (entPort[inKey] == inPort);
  assign look.genSame  = (entGen[inKey] == inGen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireValid  <= 1'b0;
      fireOffset <= '0;
      fireCtx    <= '0;
      fireGen    <= '0;
      fireWide   <= 1'b0;
      fireLeft   <= '0;
      fireRight  <= '0;
      monoValid  <= 1'b0;
      monoOffset <= '0;
      monoCtx    <= '0;
      monoInline <= 1'b0;
      monoData   <= '0;
      memValid   <= 1'b0;
      memToken   <= '0;
      sysValid   <= 1'b0;
      sysToken   <= '0;
      staleCount <= '0;
      dupError   <= 1'b0;
    end else begin
      fireValid <= str.fireEn;
      monoValid <= str.monoEn;
      memValid  <= str.memEn;
      sysValid  <= str.sysEn;
      dupError  <= str.dupPulse;
      if (str.fireEn) begin
        fireOffset <= inOfs;
        fireCtx    <= inCtx;
        fireGen    <= inGen;
        fireWide   <= inFlag | entWide[inKey];
        fireLeft   <= inPort ? entData[inKey] : inData;
        fireRight  <= inPort ? inData : entData[inKey];
      end
      if (str.monoEn) begin
        monoOffset <= inOfs;
        monoCtx    <= inCtx;
        monoInline <= inFlag;
        monoData   <= inData;
      end
      if (str.memEn) memToken <= inToken;
      if (str.sysEn) sysToken <= inToken;
      if (str.staleInc && staleCount != '1) staleCount <= staleCount + 1'b1;
    end
  end

  // R3
  one_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fireValid, monoValid, memValid, sysValid}));

  // R5
  fire_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> !entValid[{fireCtx, fireOffset}]);

  // R8
  dup_no_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    dupError |-> !fireValid);

  // R9
  stale_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> staleCount >= $past(staleCount));

endmodule

// File: rtl/operand_pairing_unit.sv
`timescale 1ns/1ps
module operand_pairing_unit
  import opu_pkg::*;
#(
  parameter int OFS_W   = 4,
  parameter int CTX_W   = 2,
  parameter int GEN_W   = 2,
  parameter int DATA_W  = 16,
  parameter int STALE_W = 8,
  localparam int KEY_W  = OFS_W + CTX_W,
  localparam int TOK_W  = 2 + OFS_W + CTX_W + 1 + GEN_W + 1 + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [TOK_W-1:0]   inToken,
  output logic               fireValid,
  output logic [OFS_W-1:0]   fireOffset,
  output logic [CTX_W-1:0]   fireCtx,
  output logic [GEN_W-1:0]   fireGen,
  output logic               fireWide,
  output logic [DATA_W-1:0]  fireLeft,
  output logic [DATA_W-1:0]  fireRight,
  output logic               monoValid,
  output logic [OFS_W-1:0]   monoOffset,
  output logic [CTX_W-1:0]   monoCtx,
  output logic               monoInline,
  output logic [DATA_W-1:0]  monoData,
  output logic               memValid,
  output logic [TOK_W-1:0]   memToken,
  output logic               sysValid,
  output logic [TOK_W-1:0]   sysToken,
  output logic [STALE_W-1:0] staleCount,
  output logic               dupError
);

  tokKind_e         tokKind;
  lookup_t          look;
  strobes_t         str;
  logic [KEY_W-1:0] sweepIdx;

  opu_ctrl #(.KEY_W(KEY_W)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tokKind(tokKind),
    .look(look), .inReady(inReady), .sweepIdx(sweepIdx), .str(str)
  );

  opu_datapath #(
    .OFS_W(OFS_W), .CTX_W(CTX_W), .GEN_W(GEN_W),
    .DATA_W(DATA_W), .STALE_W(STALE_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .inToken(inToken), .str(str),
    .sweepIdx(sweepIdx), .tokKind(tokKind), .look(look),
    .fireValid(fireValid), .fireOffset(fireOffset), .fireCtx(fireCtx),
    .fireGen(fireGen), .fireWide(fireWide), .fireLeft(fireLeft),
    .fireRight(fireRight), .monoValid(monoValid), .monoOffset(monoOffset),
    .monoCtx(monoCtx), .monoInline(monoInline), .monoData(monoData),
    .memValid(memValid), .memToken(memToken), .sysValid(sysValid),
    .sysToken(sysToken), .staleCount(staleCount), .dupError(dupError)
  );

endmodule

// File: tb/tb_operand_pairing_unit.sv
`timescale 1ns/1ps
module tb_operand_pairing_unit;

  localparam int OFS_W = 3, CTX_W = 1, GEN_W = 2, DATA_W = 16, STALE_W = 2;
  localparam int TOK_W = 2 + OFS_W + CTX_W + 1 + GEN_W + 1 + DATA_W;
  localparam int DEPTH = 1 << (OFS_W + CTX_W);

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [TOK_W-1:0] inToken = '0;
  logic inReady, fireValid, fireWide, monoValid, monoInline, memValid, sysValid, dupError;
  logic [OFS_W-1:0] fireOffset, monoOffset;
  logic [CTX_W-1:0] fireCtx, monoCtx;
  logic [GEN_W-1:0] fireGen;
  logic [DATA_W-1:0] fireLeft, fireRight, monoData;
  logic [TOK_W-1:0] memToken, sysToken;
  logic [STALE_W-1:0] staleCount;

  always #10 clk = ~clk;

  operand_pairing_unit #(.OFS_W(OFS_W), .CTX_W(CTX_W), .GEN_W(GEN_W),
    .DATA_W(DATA_W), .STALE_W(STALE_W)) dut (.*);

  int nChecks = 0, nFails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 fire, 2 mono, 3 mem, 4 sys
  typedef struct packed {
    logic [TOK_W-1:0] tok;
    logic [2:0]       kind;
    logic [2:0]       ofs;
    logic             ctx;
    logic             flag;
    logic [15:0]      a;
    logic [15:0]      b;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{{2'b00,3'd1,1'b0,1'b0,2'd0,1'b0,16'h1111}, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b00,3'd1,1'b0,1'b1,2'd0,1'b0,16'h2222}, 3'd1, 3'd1, 1'b0, 1'b0, 16'h1111, 16'h2222},
    '{{2'b00,3'd2,1'b0,1'b1,2'd1,1'b0,16'h3333}, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b00,3'd2,1'b1,1'b0,2'd1,1'b0,16'h4444}, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b00,3'd2,1'b0,1'b0,2'd1,1'b1,16'h5555}, 3'd1, 3'd2, 1'b0, 1'b1, 16'h5555, 16'h3333},
    '{{2'b01,3'd5,1'b1,1'b0,2'd0,1'b1,16'hABCD}, 3'd2, 3'd5, 1'b1, 1'b1, 16'hABCD, 16'h0000},
    '{{2'b10,3'd6,1'b0,1'b1,2'd3,1'b0,16'h0F0F}, 3'd3, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b11,3'd7,1'b1,1'b0,2'd2,1'b1,16'h7777}, 3'd4, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b00,3'd2,1'b1,1'b1,2'd1,1'b0,16'h6666}, 3'd1, 3'd2, 1'b1, 1'b0, 16'h4444, 16'h6666},
    '{{2'b00,3'd1,1'b0,1'b0,2'd2,1'b0,16'h0001}, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{{2'b00,3'd1,1'b0,1'b1,2'd2,1'b0,16'h0002}, 3'd1, 3'd1, 1'b0, 1'b0, 16'h0001, 16'h0002}
  };

  task automatic checkRow(input int r);
    vec_t v = TBL[r];
    chk("R5 fireValid", 32'(fireValid), 32'(v.kind == 3'd1));
    chk("R2 monoValid", 32'(monoValid), 32'(v.kind == 3'd2));
    chk("R3 memValid",  32'(memValid),  32'(v.kind == 3'd3));
    chk("R3 sysValid",  32'(sysValid),  32'(v.kind == 3'd4));
    if (v.kind == 3'd0) chk("R4 no output", 32'(fireValid | monoValid | memValid | sysValid), 32'd0);
    if (v.kind == 3'd1) begin
      chk("R6 fireLeft",  32'(fireLeft),  32'(v.a));
      chk("R6 fireRight", 32'(fireRight), 32'(v.b));
      chk("R6 fireWide",  32'(fireWide),  32'(v.flag));
      chk("R5 fire key",  32'({fireCtx, fireOffset}), 32'({v.ctx, v.ofs}));
    end
    if (v.kind == 3'd2) begin
      chk("R2 monoData",   32'(monoData),   32'(v.a));
      chk("R2 monoInline", 32'(monoInline), 32'(v.flag));
      chk("R2 mono key",   32'({monoCtx, monoOffset}), 32'({v.ctx, v.ofs}));
    end
    if (v.kind == 3'd3) chk("R3 memToken", 32'(memToken), 32'(v.tok));
    if (v.kind == 3'd4) chk("R3 sysToken", 32'(sysToken), 32'(v.tok));
    if (r == NV - 1) chk("R10 back-to-back pair", 32'(fireValid), 32'd1);
  endtask

  function automatic logic [TOK_W-1:0] dy(input logic [2:0] o, input logic c, input logic p,
                                          input logic [1:0] g, input logic f, input logic [15:0] d);
    return {2'b00, o, c, p, g, f, d};
  endfunction

  task automatic send(input logic [TOK_W-1:0] t);
    inValid = 1'b1;
    inToken = t;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(20 * 50000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int cycles;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 inReady in reset", 32'(inReady), 32'd0);
    chk("R1 valids in reset", 32'({fireValid, monoValid, memValid, sysValid, dupError}), 32'd0);
    chk("R1 staleCount in reset", 32'(staleCount), 32'd0);
    rstN = 1'b1;
    cycles = 0;
    while (!inReady && cycles < 1000) begin
      @(negedge clk);
      cycles++;
    end
    chk("R1 sweep length", 32'(cycles), 32'(DEPTH));
    chk("R1 valids after sweep", 32'({fireValid, monoValid, memValid, sysValid, dupError}), 32'd0);

    // table walk, one token per cycle (R10)
    for (int i = 0; i <= NV; i++) begin
      if (i < NV) begin
        inValid = 1'b1;
        inToken = TBL[i].tok;
      end else begin
        inValid = 1'b0;
      end
      if (i > 0) checkRow(i - 1);
      @(negedge clk);
    end
    inValid = 1'b0;

    // R7 generation mismatch
    send(dy(3'd3, 1'b0, 1'b0, 2'd0, 1'b0, 16'hAAAA));
    chk("R4 first arrival", 32'(fireValid), 32'd0);
    send(dy(3'd3, 1'b0, 1'b1, 2'd1, 1'b0, 16'hDEAD));
    chk("R7 stale dropped", 32'(fireValid), 32'd0);
    chk("R7 staleCount", 32'(staleCount), 32'd1);
    send(dy(3'd3, 1'b0, 1'b1, 2'd0, 1'b0, 16'hBBBB));
    chk("R7 entry kept, fires", 32'(fireValid), 32'd1);
    chk("R7 fireLeft", 32'(fireLeft), 32'hAAAA);
    chk("R7 fireRight", 32'(fireRight), 32'hBBBB);

    // R9 saturation
    send(dy(3'd6, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0606));
    send(dy(3'd6, 1'b1, 1'b1, 2'd2, 1'b0, 16'h0001));
    chk("R9 staleCount 2", 32'(staleCount), 32'd2);
    send(dy(3'd6, 1'b1, 1'b1, 2'd2, 1'b0, 16'h0002));
    chk("R9 staleCount 3", 32'(staleCount), 32'd3);
    send(dy(3'd6, 1'b1, 1'b1, 2'd3, 1'b0, 16'h0003));
    chk("R9 staleCount saturated", 32'(staleCount), 32'd3);

    // R8 duplicate overwrite
    send(dy(3'd4, 1'b0, 1'b1, 2'd3, 1'b0, 16'h1234));
    chk("R8 no error on store", 32'(dupError), 32'd0);
    send(dy(3'd4, 1'b0, 1'b1, 2'd3, 1'b0, 16'h5678));
    chk("R8 dupError pulse", 32'(dupError), 32'd1);
    chk("R8 no fire on dup", 32'(fireValid), 32'd0);
    @(negedge clk);
    chk("R8 dupError one cycle", 32'(dupError), 32'd0);
    send(dy(3'd4, 1'b0, 1'b0, 2'd3, 1'b1, 16'h9999));
    chk("R8 partner fires", 32'(fireValid), 32'd1);
    chk("R8 fireRight newer", 32'(fireRight), 32'h5678);
    chk("R6 fireLeft late L", 32'(fireLeft), 32'h9999);
    chk("R6 fireWide OR", 32'(fireWide), 32'd1);
    chk("R5 fireGen", 32'(fireGen), 32'd3);

    // R2 single-input token leaves store untouched
    send({2'b01, 3'd7, 1'b0, 1'b0, 2'd0, 1'b0, 16'hC0DE});
    chk("R2 mono out", 32'(monoValid), 32'd1);
    send(dy(3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 16'h0077));
    chk("R2 store untouched by mono", 32'(fireValid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule